// File: doc/BRIEF.md
# Dual-Regulator Power-Up Sequencer

This block is the digital controller that brings up a pair of voltage regulators in a fixed, safe order. Two enable inputs ask for power on each channel. The analog monitors around the regulators report back through single-bit flags: a supply-good comparator, a reference-ready flag, a bypass-capacitor-charged flag, and an in-regulation flag for channel 1. The block produces level strobes for the shared bias circuits and one soft-start enable for each regulator.

When either enable is raised, the block waits for a good supply. It then latches trim, and powers the bandgap, the reference and the current generator in turn. Next it fast-charges the bypass capacitor, and only after that does it let the regulators ramp. Steps that have no ready flag last a fixed dwell time. Steps that do have one advance when the flag is seen, or after a timeout; a timeout also sets a sticky fault flag.

Channel 1 takes precedence while both channels are still waiting to start. Channel 2 holds off until channel 1 is in regulation, unless channel 2 was already ramping first. A supply drop turns off both channels together and sends the block back to the beginning of bring-up.

Top module: `dual_reg_sequencer`

## Requirements
- R1: With both enables low, every strobe (`trim_latch`, `bg_on`, `ref_on`, `igen_on`, `fast_chg`) and both soft-start enables are low one cycle later, and they stay low.
- R2: With an enable high but the supply-good input low, no strobe is asserted; bring-up starts only once supply-good is seen high.
- R3: Bring-up drives strobes in this order: `trim_latch` alone for `STEP_DWELL` cycles; then `bg_on`; then `bg_on`+`ref_on`; then `bg_on`+`ref_on`+`igen_on`; then the same plus `fast_chg`. After that, `fast_chg` drops and the bias strobes stay on, and only then can a soft-start enable rise.
- R4: If channel 1 is running and channel 2 is enabled before `ok_ch1` is seen, `ss_ch2` stays low; `ss_ch2` rises two cycles after `ok_ch1` goes high.
- R5: If channel 2 is requested first and channel 1 is requested before `ss_ch2` has risen, `ss_ch1` rises first and `ss_ch2` waits for `ok_ch1`.
- R6: If `ss_ch2` is already high and channel 1 is then enabled, `ss_ch1` rises one cycle later and `ss_ch2` stays high.
- R7: If both enables rise in the same cycle, `ss_ch1` rises first and `ss_ch2` stays low until `ok_ch1` is high.
- R8: A low on supply-good turns off both soft-start enables and all strobes three clock edges later: two edges of synchronizer plus one of state. When supply-good returns high, the whole bring-up runs again without any other input.
- R9: A ready-gated step (reference, bypass charge) whose ready flag stays low advances after `STEP_TIMEOUT` cycles and sets `fault`. `fault` then stays high until reset, even through shutdown.
- R10: Dropping one channel's enable clears only that channel's soft-start enable on the next cycle; the other channel and the bias strobes are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_ch1 | input | 1 | Power request for channel 1 |
| en_ch2 | input | 1 | Power request for channel 2 |
| supply_ok_async | input | 1 | Supply comparator output (1 = above threshold, hysteresis in the comparator), asynchronous |
| ref_ready | input | 1 | Reference has settled |
| byp_charged | input | 1 | Bypass capacitor is charged |
| ok_ch1 | input | 1 | Channel 1 output has reached its target |
| trim_latch | output | 1 | Latch trim settings (high during the trim step only) |
| bg_on | output | 1 | Bandgap power |
| ref_on | output | 1 | Reference power |
| igen_on | output | 1 | Current generator power |
| fast_chg | output | 1 | Bypass capacitor fast charge (high during that step only) |
| ss_ch1 | output | 1 | Soft-start enable, channel 1 |
| ss_ch2 | output | 1 | Soft-start enable, channel 2 |
| fault | output | 1 | Sticky step-timeout flag |

## Verification
Each result is due a fixed number of edges after its stimulus. Dropping an enable takes effect one edge later. Loss of supply-good takes effect three edges later. After `ok_ch1` rises, `ss_ch2` follows in two edges. A timed-out step advances exactly `STEP_TIMEOUT` edges after it was entered. The bench drives inputs just after a falling edge and samples just before the next drive, so it can count edges exactly. It checks a result at the edge where it is due, and also at the edge before, where the old value must still hold. The random phase checks the order of the bias strobes, the channel-2 hold-off, and the one-edge enable and shutdown responses, using flags the bench keeps itself.

// File: rtl/dseq_pkg.sv
// Shared types for the dual-regulator sequencer.
package dseq_pkg;
    // Main sequencer states; the bring-up steps appear in power-on order.
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_WAIT_UV = 3'd1,
        ST_TRIM    = 3'd2,
        ST_BGAP    = 3'd3,
        ST_REF     = 3'd4,
        ST_IGEN    = 3'd5,
        ST_FCHG    = 3'd6,
        ST_RUN     = 3'd7
    } seq_state_t;
endpackage

// File: rtl/dseq_sync.sv
// Multi-flop synchronizer for a slow asynchronous level.
// Assumes the input changes rarely compared with the clock; resets to 0,
// so the supply is treated as bad until proven good.
module dseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dseq_step_timer.sv
// Cycle counter for the current sequencer step. It is cleared on every
// state change, so it reads 0 in a step's first cycle. It saturates at its
// top value so that a long wait cannot wrap around.
module dseq_step_timer #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] TOP = '1;

    // Count the cycles spent in the step, restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  count <= '0;
        else if (count != TOP) count <= count + 1'b1;
    end
endmodule

// File: rtl/dseq_chan_arb.sv
// Soft-start arbiter for the two regulator channels.
// Channel 1 always ramps as soon as it is allowed to. Channel 2 starts only
// if channel 1 is not requested, or channel 1 has reached regulation. Once
// channel 2 is ramping it keeps going. Assumes run already folds in the
// synchronized supply-good flag.
module dseq_chan_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic en_ch1,
    input  logic en_ch2,
    input  logic ok_ch1,
    output logic ss_ch1,
    output logic ss_ch2
);
    logic ch1_d, ch2_d, aok_d, aok_q;

    // Work out the next soft-start levels and the channel-1-reached flag.
    always_comb begin
        ch1_d = run && en_ch1;
        aok_d = ch1_d && (aok_q || (ss_ch1 && ok_ch1));
        ch2_d = run && en_ch2 && (ss_ch2 || !en_ch1 || aok_q);
    end

    // Register the soft-start enables and the reached flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_ch1 <= 1'b0;
            ss_ch2 <= 1'b0;
            aok_q  <= 1'b0;
        end else begin
            ss_ch1 <= ch1_d;
            ss_ch2 <= ch2_d;
            aok_q  <= aok_d;
        end
    end

    // Channel 2 may not start beside a running channel 1 that is not yet in regulation.
    assert_ch2_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ss_ch2) && ss_ch1) |-> $past(aok_q));

    // Dropping channel 1's request clears only its own enable on the next edge.
    assert_ch1_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_ch1) |=> !ss_ch1);
endmodule

// File: rtl/dual_reg_sequencer.sv
// Power-up sequencer for two regulators sharing bias circuits.
// It waits for a good supply, runs the bias steps in order, and hands the
// regulators to the channel arbiter. Assumes ref_ready, byp_charged and
// ok_ch1 are already synchronous to clk; only the supply flag is synchronized here.
module dual_reg_sequencer #(
    parameter int STEP_DWELL   = 2,
    parameter int STEP_TIMEOUT = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_ch1,
    input  logic en_ch2,
    input  logic supply_ok_async,
    input  logic ref_ready,
    input  logic byp_charged,
    input  logic ok_ch1,
    output logic trim_latch,
    output logic bg_on,
    output logic ref_on,
    output logic igen_on,
    output logic fast_chg,
    output logic ss_ch1,
    output logic ss_ch2,
    output logic fault
);
    import dseq_pkg::*;

    localparam int MAX_WAIT = (STEP_TIMEOUT > STEP_DWELL) ? STEP_TIMEOUT : STEP_DWELL;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] DWELL_LAST   = CNT_W'(STEP_DWELL - 1);
    localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(STEP_TIMEOUT - 1);

    seq_state_t       state_q, state_d;
    logic             supply_ok;
    logic [CNT_W-1:0] step_cnt;
    logic             dwell_done, wait_done, step_fault, any_en, run;

    // Bring the asynchronous supply comparator into the clock domain.
    dseq_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(supply_ok_async),
        .q_sync (supply_ok)
    );

    // Time the current step.
    dseq_step_timer #(.WIDTH(CNT_W)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(state_d != state_q),
        .count(step_cnt)
    );

    assign any_en     = en_ch1 || en_ch2;
    assign dwell_done = (step_cnt == DWELL_LAST);
    assign wait_done  = (step_cnt == TIMEOUT_LAST);

    // Choose the next state and flag any ready-step timeout.
    always_comb begin
        state_d    = state_q;
        step_fault = 1'b0;
        if (!any_en) begin
            state_d = ST_OFF;
        end else if (state_q == ST_OFF) begin
            state_d = ST_WAIT_UV;
        end else if (!supply_ok) begin
            state_d = ST_WAIT_UV;
        end else begin
            case (state_q)
                ST_WAIT_UV: state_d = ST_TRIM;
                ST_TRIM:    if (dwell_done) state_d = ST_BGAP;
                ST_BGAP:    if (dwell_done) state_d = ST_REF;
                ST_REF: begin
                    if (ref_ready) state_d = ST_IGEN;
                    else if (wait_done) begin
                        state_d    = ST_IGEN;
                        step_fault = 1'b1;
                    end
                end
                ST_IGEN:    if (dwell_done) state_d = ST_FCHG;
                ST_FCHG: begin
                    if (byp_charged) state_d = ST_RUN;
                    else if (wait_done) begin
                        state_d    = ST_RUN;
                        step_fault = 1'b1;
                    end
                end
                default:    state_d = state_q;
            endcase
        end
    end

    // Hold the sequencer state and the sticky fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            fault   <= 1'b0;
        end else begin
            state_q <= state_d;
            fault   <= fault || step_fault;
        end
    end

    // Decode the bias strobes from the state; each bias stays on once reached.
    always_comb begin
        trim_latch = (state_q == ST_TRIM);
        bg_on      = (state_q >= ST_BGAP);
        ref_on     = (state_q >= ST_REF);
        igen_on    = (state_q >= ST_IGEN);
        fast_chg   = (state_q == ST_FCHG);
    end

    assign run = (state_q == ST_RUN) && supply_ok;

    // Give the regulators their soft-start enables in priority order.
    dseq_chan_arb i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .en_ch1(en_ch1),
        .en_ch2(en_ch2),
        .ok_ch1(ok_ch1),
        .ss_ch1(ss_ch1),
        .ss_ch2(ss_ch2)
    );

    // With no request, everything is off on the next edge.
    assert_shutdown_all_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_ch1 && !en_ch2) |=> (!trim_latch && !bg_on && !fast_chg && !ss_ch1 && !ss_ch2));

    // A regulator ramps only with all bias up and the fast charge finished.
    assert_ramp_after_bias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_ch1 || ss_ch2) |-> (bg_on && ref_on && igen_on && !fast_chg && !trim_latch));

    // A bad supply seen by the synchronizer removes both ramps next edge.
    assert_supply_loss_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok) |=> (!ss_ch1 && !ss_ch2));

    // A fault, once set, is kept.
    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
endmodule

// File: tb/test_dual_reg_sequencer.sv
`timescale 1ns/1ps
module test_dual_reg_sequencer;
    localparam int DWELL   = 2;
    localparam int TIMEOUT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en1 = 1'b0, en2 = 1'b0, sup = 1'b0, rdy_ref = 1'b1, rdy_byp = 1'b1, ok1 = 1'b0;
    logic trim, bg, rf, ig, fc, ss1, ss2, flt;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    dual_reg_sequencer #(.STEP_DWELL(DWELL), .STEP_TIMEOUT(TIMEOUT), .SYNC_STAGES(2)) i_dual_reg_sequencer (
        .clk(clk), .rst_n(rst_n), .en_ch1(en1), .en_ch2(en2), .supply_ok_async(sup),
        .ref_ready(rdy_ref), .byp_charged(rdy_byp), .ok_ch1(ok1),
        .trim_latch(trim), .bg_on(bg), .ref_on(rf), .igen_on(ig), .fast_chg(fc),
        .ss_ch1(ss1), .ss_ch2(ss2), .fault(flt)
    );

    function automatic logic [6:0] outs();
        return {trim, bg, rf, ig, fc, ss1, ss2};
    endfunction

    // Expected strobe pattern for each bring-up stage, in order.
    function automatic logic [6:0] exp_stage(int idx);
        case (idx)
            0: return 7'b1000000;
            1: return 7'b0100000;
            2: return 7'b0110000;
            3: return 7'b0111000;
            4: return 7'b0111100;
            5: return 7'b0111000;
            6: return 7'b0111010;
            default: return 7'b0000000;
        endcase
    endfunction

    // Bias ordering must always hold.
    function automatic bit order_ok(logic [6:0] v);
        logic t, b, r, i, f, a, c;
        {t, b, r, i, f, a, c} = v;
        if (t && b) return 1'b0;
        if (r && !b) return 1'b0;
        if (i && !r) return 1'b0;
        if (f && !i) return 1'b0;
        if ((a || c) && (!i || f)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en1 = 0; en2 = 0; ok1 = 0; rdy_ref = 1; rdy_byp = 1;
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
    endtask

    // Wait until a soft-start enable is high, bounded.
    task automatic wait_ss1(string req);
        int k = 0;
        while (!ss1 && k < 100) begin cyc(1); k++; end
        check(req, "ss_ch1 reached", 32'(ss1), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EC0_0042));
        cyc(3);
        check("R1", "reset outputs", 32'({outs(), flt}), 32'd0);
        rst_n = 1'b1;
        sup = 1'b1;
        cyc(4);
        check("R1", "idle outputs", 32'(outs()), 32'd0);

        // R3: bring-up order with all ready flags high.
        begin
            logic [6:0] prev = '0;
            int idx = 0, trim_cycles = 0;
            en1 = 1'b1;
            for (int k = 0; k < 80 && idx < 7; k++) begin
                cyc(1);
                if (trim) trim_cycles++;
                if (outs() != prev && outs() != 0) begin
                    check("R3", $sformatf("stage %0d", idx), 32'(outs()), 32'(exp_stage(idx)));
                    idx++;
                end
                prev = outs();
            end
            check("R3", "stages seen", 32'(idx), 32'd7);
            check("R3", "trim dwell", 32'(trim_cycles), 32'(DWELL));
        end

        // R4: channel 2 held until channel 1 in regulation.
        en2 = 1'b1;
        cyc(10);
        check("R4", "ss_ch2 held", 32'(ss2), 32'd0);
        ok1 = 1'b1;
        cyc(1);
        check("R4", "ss_ch2 one edge after ok", 32'(ss2), 32'd0);
        cyc(1);
        check("R4", "ss_ch2 two edges after ok", 32'(ss2), 32'd1);

        // R10: drop channel 1 only.
        en1 = 1'b0;
        cyc(1);
        check("R10", "ss_ch1 off", 32'(ss1), 32'd0);
        check("R10", "ss_ch2 kept", 32'(ss2), 32'd1);
        check("R10", "bias kept", 32'({bg, rf, ig}), 32'b111);

        // R6: channel 2 ramping, channel 1 arrives and starts at once.
        ok1 = 1'b0;
        en1 = 1'b1;
        cyc(1);
        check("R6", "ss_ch1 immediate", 32'(ss1), 32'd1);
        check("R6", "ss_ch2 kept", 32'(ss2), 32'd1);

        // R1: both low gives shutdown next edge.
        en1 = 1'b0; en2 = 1'b0;
        cyc(1);
        check("R1", "shutdown", 32'(outs()), 32'd0);
        cyc(5);
        check("R1", "shutdown holds", 32'(outs()), 32'd0);

        // R2: no start while the supply is low.
        sup = 1'b0;
        cyc(4);
        en2 = 1'b1;
        cyc(20);
        check("R2", "no strobes without supply", 32'(outs()), 32'd0);

        // R5: channel 1 requested before channel 2 ramps.
        en1 = 1'b1;
        cyc(2);
        sup = 1'b1;
        wait_ss1("R5");
        check("R5", "ss_ch2 waits", 32'(ss2), 32'd0);
        cyc(5);
        check("R5", "ss_ch2 still waits", 32'(ss2), 32'd0);
        ok1 = 1'b1;
        cyc(2);
        check("R5", "ss_ch2 after ok", 32'(ss2), 32'd1);

        // R8: supply loss three edges later, then automatic restart.
        sup = 1'b0;
        cyc(2);
        check("R8", "still on at edge 2", 32'({ss1, ss2}), 32'b11);
        cyc(1);
        check("R8", "off at edge 3", 32'(outs()), 32'd0);
        ok1 = 1'b0;
        cyc(5);
        sup = 1'b1;
        wait_ss1("R8");
        check("R8", "restart ch2 waits", 32'(ss2), 32'd0);

        // R7: both enables rise together.
        en1 = 1'b0; en2 = 1'b0;
        cyc(3);
        en1 = 1'b1; en2 = 1'b1;
        wait_ss1("R7");
        check("R7", "ch2 not first", 32'(ss2), 32'd0);
        ok1 = 1'b1;
        cyc(2);
        check("R7", "ch2 after ok", 32'(ss2), 32'd1);

        // R9: reference step times out.
        do_reset();
        check("R9", "fault clear after reset", 32'(flt), 32'd0);
        rdy_ref = 1'b0;
        en1 = 1'b1;
        begin
            int k = 0, span = 0;
            while (!rf && k < 50) begin cyc(1); k++; end
            while (!ig && span < 100) begin cyc(1); span++; end
            check("R9", "timeout length", 32'(span), 32'(TIMEOUT));
            check("R9", "fault set", 32'(flt), 32'd1);
        end
        en1 = 1'b0;
        cyc(3);
        check("R9", "fault sticky in shutdown", 32'(flt), 32'd1);
        rdy_ref = 1'b1;

        // Random phase: ordering, priority, enable and shutdown response.
        do_reset();
        begin
            bit a_seen = 1'b0;
            logic ss2_prev = 1'b0;
            logic p_en1 = 1'b0, p_en2 = 1'b0;
            for (int k = 0; k < 4000; k++) begin
                cyc(1);
                check("R3", "bias order", 32'(order_ok(outs())), 32'd1);
                if (!p_en1 && !p_en2) check("R1", "random shutdown", 32'(outs()), 32'd0);
                if (!p_en1) check("R10", "random ch1 drop", 32'(ss1), 32'd0);
                if (ss2 && !ss2_prev && ss1)
                    check("R4", "random ch2 start", 32'(a_seen), 32'd1);
                a_seen   = ss1 && (a_seen || ok1);
                ss2_prev = ss2;
                if ($urandom_range(39) == 0) en1 = ~en1;
                if ($urandom_range(39) == 0) en2 = ~en2;
                if ($urandom_range(7) == 0)  ok1 = ~ok1;
                if ($urandom_range(299) == 0) sup = ~sup;
                rdy_ref = ($urandom_range(3) != 0);
                rdy_byp = ($urandom_range(3) != 0);
                p_en1 = en1;
                p_en2 = en2;
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule